// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block sits between the clock synthesizers of a clock generator and its output pins. It receives five free-running clock groups: CPU, PCI reference, REF, OUT and OUT_DIV2. It forwards each group to its pins only while no stop request applies to that group.

Four active-low requests act on the groups:
- A CPU halt request stops the CPU group.
- A PCI halt request stops the PCI reference group.
- A fixed-PLL sleep request stops OUT and OUT_DIV2.
- A full sleep request stops every group, then turns off the crystal and VCO enables.

All requests are asynchronous. Each one passes through a synchronizer before it has any effect. A group's gate opens or closes only while that group's clock is low. As a result, a pin always parks low and never shows a shortened high pulse.

The block runs on a fast sampling clock. The group clocks arrive as levels that this clock oversamples, and every output is registered in the same domain. After reset, or when full sleep is released, the block raises the crystal and VCO enables first. It then waits a parameterized number of REF rising edges before it opens any gate. A per-group status vector shows which groups are currently held.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While the CPU halt request is low (after synchronization), all CPU pins stay at 0 and the other four groups keep toggling.
- R2: While the PCI halt request is low, the PCI reference pin stays at 0 and the other four groups keep toggling.
- R3: Each request passes a two-stage synchronizer. A request cannot change a group's status earlier than three sampling-clock edges after it is applied.
- R4: A gate changes only while its source clock is low. Every high pulse on any pin has the full high width of its source, including the first pulse after a restart.
- R5: On full sleep, every group parks low before the crystal and VCO enables drop. While the enables are low, all pins stay at 0.
- R6: With full sleep released and the fixed-PLL sleep request low, only OUT and OUT_DIV2 stop. CPU, PCI and REF keep running.
- R7: The sequencer waits as many cycles as the slow REF group needs to reach a low phase and park. The enables never drop while a REF pin is high or the REF gate is open.
- R8: After reset, or after full sleep is released, both enables are high while every gate is still closed. No gate opens before STAB_CYCLES rising edges of the REF source have been counted.
- R9: Out of reset, all pins are 0, the status vector is all ones and both enables are 1. Once stabilization ends, all five groups run.
- R10: The status vector reports each group as held, 1, or passing, 0. The bit order is CPU = bit 0, PCI = bit 1, REF = bit 2, OUT = bit 3, OUT_DIV2 = bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src_i | input | 1 | Ungated CPU group clock level |
| pci_src_i | input | 1 | Ungated PCI reference clock level |
| ref_src_i | input | 1 | Ungated REF clock level |
| out_src_i | input | 1 | Ungated OUT clock level |
| outd_src_i | input | 1 | Ungated OUT_DIV2 clock level |
| cpu_halt_n_i | input | 1 | Asynchronous CPU halt request, active low |
| pci_halt_n_i | input | 1 | Asynchronous PCI halt request, active low |
| sleep_n_i | input | 1 | Asynchronous full sleep request, active low |
| fix_sleep_n_i | input | 1 | Asynchronous fixed-PLL sleep request, active low |
| cpu_clk_o | output | NUM_CPU | Gated CPU clock pins |
| pci_clk_o | output | 1 | Gated PCI reference pin |
| ref_clk_o | output | NUM_REF | Gated REF pins |
| out_clk_o | output | 1 | Gated OUT pin |
| outd_clk_o | output | 1 | Gated OUT_DIV2 pin |
| grp_held_o | output | 5 | Per-group held status, see R10 |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |

## Verification
The bench builds the block with STAB_CYCLES = 4 and keeps the defaults of 12 CPU pins, 2 REF pins and two synchronizer stages. The default stabilization count of about three milliseconds of REF edges would make every wake-up far too long for a bench. With a count of 4, a wake-up takes about 64 sampling cycles, so the bench can cover reset, several sleep and wake round trips, and each halt request within one short run. The source clocks use high widths of 2, 4, 8, 4 and 8 sampling cycles. This makes REF the slowest group, so the parking wait of R7 is exercised over several cycles.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

    localparam int GRP_N    = 5;
    localparam int GRP_CPU  = 0;
    localparam int GRP_PCI  = 1;
    localparam int GRP_REF  = 2;
    localparam int GRP_OUT  = 3;
    localparam int GRP_OUTD = 4;

    typedef enum logic [1:0] {
        SEQ_WAKE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_PARK = 2'd2,
        SEQ_OFF  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic gate;
        logic pin;
    } gate_st_t;

endpackage

// File: rtl/req_sync.sv
module req_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/grp_gate.sv
module grp_gate
    import clk_stop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic run_i,
    output logic pin_o,
    output logic held_o
);
    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!src_i) st_d.gate = run_i;
        st_d.pin = src_i & st_d.gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o  = st_q.pin;
    assign held_o = ~st_q.gate;
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import clk_stop_pkg::*;
#(
    parameter int STAB_CYCLES = 43000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n_s_i,
    input  logic ref_src_i,
    input  logic all_parked_i,
    output logic run_o,
    output logic xtal_en_o,
    output logic vco_en_o
);
    localparam int CW = $clog2(STAB_CYCLES + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          ref_prev;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    ref_rise;

    always_comb begin
        st_d          = st_q;
        ref_rise      = ref_src_i & ~st_q.ref_prev;
        st_d.ref_prev = ref_src_i;
        unique case (st_q.st)
            SEQ_WAKE: begin
                if (!sleep_n_s_i) begin
                    st_d.st = SEQ_PARK;
                end else if (ref_rise) begin
                    if (st_q.cnt == CW'(STAB_CYCLES - 1)) begin
                        st_d.st  = SEQ_RUN;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            SEQ_RUN:  if (!sleep_n_s_i) st_d.st = SEQ_PARK;
            SEQ_PARK: if (all_parked_i) st_d.st = SEQ_OFF;
            SEQ_OFF: begin
                if (sleep_n_s_i) begin
                    st_d.st  = SEQ_WAKE;
                    st_d.cnt = '0;
                end
            end
            default:  st_d.st = SEQ_PARK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st       <= SEQ_WAKE;
            st_q.cnt      <= '0;
            st_q.ref_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o     = (st_q.st == SEQ_RUN);
    assign xtal_en_o = (st_q.st != SEQ_OFF);
    assign vco_en_o  = (st_q.st != SEQ_OFF);
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
    import clk_stop_pkg::*;
#(
    parameter int NUM_CPU     = 12,
    parameter int NUM_REF     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int STAB_CYCLES = 43000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_src_i,
    input  logic               pci_src_i,
    input  logic               ref_src_i,
    input  logic               out_src_i,
    input  logic               outd_src_i,
    input  logic               cpu_halt_n_i,
    input  logic               pci_halt_n_i,
    input  logic               sleep_n_i,
    input  logic               fix_sleep_n_i,
    output logic [NUM_CPU-1:0] cpu_clk_o,
    output logic               pci_clk_o,
    output logic [NUM_REF-1:0] ref_clk_o,
    output logic               out_clk_o,
    output logic               outd_clk_o,
    output logic [GRP_N-1:0]   grp_held_o,
    output logic               xtal_en_o,
    output logic               vco_en_o
);
    localparam int REQ_N = 4;

    logic [REQ_N-1:0] req_s;
    logic [GRP_N-1:0] src, run, pin;
    logic             seq_run, all_parked;

    req_sync #(.STAGES(SYNC_STAGES), .WIDTH(REQ_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({fix_sleep_n_i, sleep_n_i, pci_halt_n_i, cpu_halt_n_i}),
        .sync_o (req_s)
    );

    pwr_seq #(.STAB_CYCLES(STAB_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_n_s_i (req_s[2]),
        .ref_src_i   (ref_src_i),
        .all_parked_i(all_parked),
        .run_o       (seq_run),
        .xtal_en_o   (xtal_en_o),
        .vco_en_o    (vco_en_o)
    );

    always_comb begin
        src            = '0;
        src[GRP_CPU]   = cpu_src_i;
        src[GRP_PCI]   = pci_src_i;
        src[GRP_REF]   = ref_src_i;
        src[GRP_OUT]   = out_src_i;
        src[GRP_OUTD]  = outd_src_i;
        run            = '0;
        run[GRP_CPU]   = seq_run & req_s[0];
        run[GRP_PCI]   = seq_run & req_s[1];
        run[GRP_REF]   = seq_run;
        run[GRP_OUT]   = seq_run & req_s[3];
        run[GRP_OUTD]  = seq_run & req_s[3];
    end

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        grp_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .src_i (src[g]),
            .run_i (run[g]),
            .pin_o (pin[g]),
            .held_o(grp_held_o[g])
        );
    end

    assign all_parked = (&grp_held_o) & ~(|pin);

    assign cpu_clk_o  = {NUM_CPU{pin[GRP_CPU]}};
    assign pci_clk_o  = pin[GRP_PCI];
    assign ref_clk_o  = {NUM_REF{pin[GRP_REF]}};
    assign out_clk_o  = pin[GRP_OUT];
    assign outd_clk_o = pin[GRP_OUTD];
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk
    import clk_stop_pkg::*;
#(
    parameter int NUM_CPU = 12,
    parameter int NUM_REF = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [GRP_N-1:0]   src,
    input logic               cpu_halt_n_i,
    input logic               seq_run,
    input logic [NUM_CPU-1:0] cpu_clk_o,
    input logic               pci_clk_o,
    input logic [NUM_REF-1:0] ref_clk_o,
    input logic               out_clk_o,
    input logic               outd_clk_o,
    input logic [GRP_N-1:0]   grp_held_o,
    input logic               xtal_en_o,
    input logic               vco_en_o
);
    logic pins_low;
    assign pins_low = (cpu_clk_o == '0) && !pci_clk_o && (ref_clk_o == '0)
                      && !out_clk_o && !outd_clk_o;

    p_cpu_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        grp_held_o[GRP_CPU] |-> (cpu_clk_o == '0));

    p_pci_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grp_held_o[GRP_PCI] |-> !pci_clk_o);

    p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_held_o[GRP_CPU]) |-> (!$past(cpu_halt_n_i, 3) || !$past(seq_run)));

    for (genvar g = 0; g < GRP_N; g++) begin : g_runt
        p_no_runt_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(grp_held_o[g]) || $fell(grp_held_o[g])) |-> !$past(src[g]));
    end

    p_park_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en_o) |-> (pins_low && (&grp_held_o)));

    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vco_en_o || !xtal_en_o) |-> (pins_low && (&grp_held_o)));

    p_ref_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xtal_en_o) |-> (grp_held_o[GRP_REF] && (ref_clk_o == '0)));

    p_wake_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xtal_en_o) |-> (&grp_held_o));
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.NUM_CPU(NUM_CPU), .NUM_REF(NUM_REF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src         (src),
    .cpu_halt_n_i(cpu_halt_n_i),
    .seq_run     (seq_run),
    .cpu_clk_o   (cpu_clk_o),
    .pci_clk_o   (pci_clk_o),
    .ref_clk_o   (ref_clk_o),
    .out_clk_o   (out_clk_o),
    .outd_clk_o  (outd_clk_o),
    .grp_held_o  (grp_held_o),
    .xtal_en_o   (xtal_en_o),
    .vco_en_o    (vco_en_o)
);

// File: tb/tb_clk_stop_ctrl.sv
`timescale 1ns/1ps
module tb_clk_stop_ctrl;
    localparam int NUM_CPU = 12;
    localparam int NUM_REF = 2;
    localparam int STAB    = 4;
    localparam int MAXCYC  = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_halt_n = 1'b1, pci_halt_n = 1'b1, sleep_n = 1'b1, fix_sleep_n = 1'b1;
    logic [7:0] phase = '0;
    logic cpu_src, pci_src, ref_src, out_src, outd_src;
    logic [NUM_CPU-1:0] cpu_clk;
    logic pci_clk, out_clk, outd_clk, xtal_en, vco_en;
    logic [NUM_REF-1:0] ref_clk;
    logic [4:0] held;

    int n_chk = 0, n_fail = 0, runt_err = 0;
    int rises[5];
    bit done = 0;

    always #2 clk = ~clk;

    always @(negedge clk) phase <= phase + 1'b1;
    assign cpu_src  = phase[1];
    assign pci_src  = phase[2];
    assign ref_src  = phase[3];
    assign out_src  = ~phase[2];
    assign outd_src = phase[3];

    clk_stop_ctrl #(.NUM_CPU(NUM_CPU), .NUM_REF(NUM_REF), .SYNC_STAGES(2), .STAB_CYCLES(STAB)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_src_i(cpu_src), .pci_src_i(pci_src), .ref_src_i(ref_src),
        .out_src_i(out_src), .outd_src_i(outd_src),
        .cpu_halt_n_i(cpu_halt_n), .pci_halt_n_i(pci_halt_n),
        .sleep_n_i(sleep_n), .fix_sleep_n_i(fix_sleep_n),
        .cpu_clk_o(cpu_clk), .pci_clk_o(pci_clk), .ref_clk_o(ref_clk),
        .out_clk_o(out_clk), .outd_clk_o(outd_clk), .grp_held_o(held),
        .xtal_en_o(xtal_en), .vco_en_o(vco_en)
    );

    function automatic logic [4:0] pins();
        return {outd_clk, out_clk, ref_clk[0], pci_clk, cpu_clk[0]};
    endfunction

    // R4 monitor: each high run must match the source high width
    int hi_len[5];
    int exp_hi[5] = '{2, 4, 8, 4, 8};
    always @(posedge clk) begin
        #1;
        for (int g = 0; g < 5; g++) begin
            if (pins()[g]) hi_len[g]++;
            else begin
                if (hi_len[g] != 0 && hi_len[g] != exp_hi[g]) begin
                    runt_err++;
                    $display("short pulse group %0d len %0d", g, hi_len[g]);
                end
                hi_len[g] = 0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic observe(input int n);
        logic [4:0] prev;
        for (int g = 0; g < 5; g++) rises[g] = 0;
        prev = pins();
        for (int i = 0; i < n; i++) begin
            tick(1);
            for (int g = 0; g < 5; g++) if (pins()[g] && !prev[g]) rises[g]++;
            prev = pins();
        end
    endtask

    task automatic wait_first_cpu_high(output int cyc);
        cyc = 0;
        while (!cpu_clk[0] && cyc < 1000) begin
            tick(1);
            cyc++;
        end
    endtask

    task automatic t_reset();
        int cyc;
        tick(1);
        check(pins() == 5'b0, "R9 reset pins", pins(), 0);
        check(held == 5'b11111, "R9 reset held", held, 31);
        check(xtal_en && vco_en, "R9 reset enables", {xtal_en, vco_en}, 3);
        wait_first_cpu_high(cyc);
        check(cyc >= (STAB-1)*16 && cyc <= (STAB+1)*16 + 16, "R8 stabilization delay", cyc, STAB*16);
        tick(20);
        observe(64);
        check(rises[0] > 0 && rises[1] > 0 && rises[2] > 0 && rises[3] > 0 && rises[4] > 0,
              "R9 all groups run", rises[2], 4);
        check(held == 5'b0, "R10 held clear when running", held, 0);
    endtask

    task automatic t_cpu_halt();
        @(negedge clk) cpu_halt_n = 1'b0;
        tick(1);
        check(held[0] == 1'b0, "R3 no change after one edge", held[0], 0);
        tick(1);
        check(held[0] == 1'b0, "R3 no change after two edges", held[0], 0);
        tick(20);
        observe(64);
        check(rises[0] == 0 && cpu_clk == '0, "R1 cpu held low", rises[0], 0);
        check(rises[1] > 0 && rises[2] > 0 && rises[3] > 0 && rises[4] > 0, "R1 others run", rises[1], 8);
        check(held == 5'b00001, "R10 cpu status", held, 1);
        @(negedge clk) cpu_halt_n = 1'b1;
        tick(20);
        observe(32);
        check(rises[0] > 0 && held == 5'b0, "R1 cpu restarts", rises[0], 8);
    endtask

    task automatic t_pci_halt();
        @(negedge clk) pci_halt_n = 1'b0;
        tick(20);
        observe(64);
        check(rises[1] == 0 && !pci_clk, "R2 pci held low", rises[1], 0);
        check(rises[0] > 0 && rises[2] > 0 && rises[3] > 0 && rises[4] > 0, "R2 others run", rises[0], 16);
        check(held == 5'b00010, "R10 pci status", held, 2);
        @(negedge clk) pci_halt_n = 1'b1;
        tick(20);
        observe(32);
        check(rises[1] > 0, "R2 pci restarts", rises[1], 4);
    endtask

    task automatic t_fix_sleep();
        @(negedge clk) fix_sleep_n = 1'b0;
        tick(30);
        observe(64);
        check(rises[3] == 0 && rises[4] == 0, "R6 out groups stopped", rises[3] + rises[4], 0);
        check(rises[0] > 0 && rises[1] > 0 && rises[2] > 0, "R6 core groups run", rises[2], 4);
        check(held == 5'b11000 && xtal_en && vco_en, "R6 status and enables", held, 24);
        @(negedge clk) fix_sleep_n = 1'b1;
        tick(30);
        observe(32);
        check(rises[3] > 0 && rises[4] > 0, "R6 out groups restart", rises[4], 2);
    endtask

    task automatic t_sleep();
        int cyc = 0;
        int cyc2;
        @(negedge clk) sleep_n = 1'b0;
        while (vco_en && cyc < 200) begin
            tick(1);
            cyc++;
        end
        check(!vco_en && !xtal_en, "R5 enables dropped", vco_en, 0);
        check(pins() == 5'b0 && held == 5'b11111, "R5 parked before off", pins(), 0);
        check(ref_clk == '0 && held[2], "R7 ref parked before off", ref_clk, 0);
        observe(64);
        check(rises[0] + rises[1] + rises[2] + rises[3] + rises[4] == 0 && !vco_en,
              "R5 quiet while off", rises[0], 0);
        @(negedge clk) sleep_n = 1'b1;
        tick(5);
        check(xtal_en && vco_en && held == 5'b11111, "R8 enables first, gates closed", held, 31);
        wait_first_cpu_high(cyc2);
        check(cyc2 >= (STAB-1)*16 - 5 && cyc2 <= (STAB+1)*16 + 16, "R8 wake delay", cyc2, STAB*16);
        tick(20);
        observe(64);
        check(rises[0] > 0 && rises[2] > 0 && rises[4] > 0 && held == 5'b0, "R9 running after wake", held, 0);
    endtask

    task automatic finish_run();
        check(runt_err == 0, "R4 full-width high pulses", runt_err, 0);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        tick(5);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_cpu_halt();
        t_pci_halt();
        t_fix_sleep();
        t_sleep();
        @(negedge clk) begin
            cpu_halt_n = 1'b0;
            sleep_n = 1'b0;
        end
        tick(100);
        check(!vco_en && pins() == 5'b0, "R5 sleep with cpu halted", pins(), 0);
        done = 1;
        finish_run();
    end

    initial begin
        #(4 * MAXCYC);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule